// File: doc/BRIEF.md
# Alternate Station Address Loader

After reset, this sequencer checks a 16-bit-word nonvolatile memory for an optional replacement station address. It reads a compatibility word and then a pointer word. If the pointer refers to a real location, it fetches three address words from there. If the fetched address is a unicast address, the sequencer writes it into receive address entry 0 as a low and a high register write. That write replaces the factory address.

A one-cycle `start` pulse begins a run. The NVM side is a request/acknowledge read port. The request stays asserted with a stable address until an acknowledge returns the data, together with an error flag. When the run ends, `done` pulses for one cycle. The 2-bit status shows one of four outcomes: the address was written, no alternate address exists, the address was rejected, or a read failed.

Top module: `alt_addr_loader`

## Requirements
- R1: While reset is asserted, and directly after it, `busy`, `done`, `nvm_rd_req` and `rar_wr_en` are 0 and `status` is 0.
- R2: After `start`, the first read is at parameter address COMPAT_ADDR (default 0x0003) and the second read is at PTR_ADDR (default 0x0037).
- R3: A read acknowledged with `nvm_rd_err`=1 ends the run with status 3 (error). No further reads follow and no register is written.
- R4: A pointer of 0x0000 or 0xFFFF ends the run with status 1 (none). No address word is read and no register is written.
- R5: The three address words are read at base, base+1 and base+2, with 16-bit wraparound. The base is the pointer when `port_func` is 0 at `start`, and the pointer plus PORT1_OFS (default 3) when it is 1.
- R6: Address word k supplies address byte 2k from its bits 7:0 and address byte 2k+1 from its bits 15:8.
- R7: If bit 0 of address byte 0 is 1 (a group address), the run ends with status 2 (ignored) and no register is written.
- R8: The low register write (`rar_wr_high`=0) carries bytes 3..0 of the address, with byte 0 in bits 7:0.
- R9: The high register write (`rar_wr_high`=1) carries byte 4 in bits 7:0 and byte 5 in bits 15:8. Bits 30:16 are zero. Bit 31 is 1 exactly when the 48-bit address is non-zero.
- R10: A written address produces exactly two write cycles, the low write first. The high write comes two cycles after the low write, with one idle cycle between them. The run then ends with status 0 (written).
- R11: `done` is high for exactly one cycle per run. After that, `status` holds until the next run. A `start` that arrives while `busy` is 1 has no effect.
- R12: While `nvm_rd_req` is 1 and no acknowledge has arrived, the request stays high and `nvm_rd_addr` does not change. Reads and register writes never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| port_func | input | 1 | Port function number, sampled at start |
| nvm_rd_req | output | 1 | NVM read request, held until acknowledge |
| nvm_rd_addr | output | AW | NVM word address |
| nvm_rd_ack | input | 1 | Read acknowledge; data and error valid |
| nvm_rd_data | input | 16 | Read data word |
| nvm_rd_err | input | 1 | Read failed |
| rar_wr_en | output | 1 | Receive address register write strobe |
| rar_wr_high | output | 1 | 0 selects the low register, 1 the high register |
| rar_wr_data | output | 32 | Register write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 written, 1 none, 2 ignored, 3 error |

## Verification
The hardest cases to reach from the ports are the late read failures, on the second or third address word, and the pointer/offset sums that wrap past 0xFFFF. Both occur only after a particular pointer and port number have already steered the run. The bench's memory model fails exactly the Nth acknowledged read, for every N from the first to the fifth. It combines each failure point with pointers near the top of the address space and with both port numbers. It also logs every address it serves, which shows whether the wrapped base was applied.

// File: rtl/alt_addr_pkg.sv
package alt_addr_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned WORD_BYTES = 2;
  localparam int unsigned NUM_WORDS  = ADDR_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W      = $clog2(NUM_WORDS);

  typedef enum logic [1:0] {
    ST_WRITTEN = 2'd0,
    ST_NONE    = 2'd1,
    ST_IGNORED = 2'd2,
    ST_ERROR   = 2'd3
  } ld_status_e;

  typedef enum logic [1:0] {
    SEL_COMPAT = 2'd0,
    SEL_PTR    = 2'd1,
    SEL_WORD   = 2'd2
  } rd_sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_COMPAT, S_RD_PTR, S_RD_WORD, S_CHECK,
    S_WR_LO, S_GAP, S_WR_HI, S_FINISH
  } seq_state_e;
endpackage

// File: rtl/alt_addr_ptr_calc.sv
module alt_addr_ptr_calc
  import alt_addr_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter logic [15:0] PORT1_OFS = 16'h0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             port1,
  input  logic [15:0]      ptr_in,
  input  logic [IDX_W-1:0] idx,
  output logic             ptr_absent,
  output logic [AW-1:0]    word_addr
);
  logic [AW-1:0] base_q, base_d;

  assign ptr_absent = (ptr_in == 16'h0000) || (ptr_in == 16'hFFFF);

  always_comb begin
    base_d = base_q;
    if (load) base_d = AW'(ptr_in) + (port1 ? AW'(PORT1_OFS) : AW'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign word_addr = base_q + AW'(idx);
endmodule

// File: rtl/alt_addr_word_store.sv
module alt_addr_word_store
  import alt_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      data,
  output logic [31:0]      lo_word,
  output logic [15:0]      hi_half,
  output logic             group_bit,
  output logic             nonzero
);
  logic [15:0] word_q [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q[k] <= '0;
      else if (hit) word_q[k] <= data;
    end
  end

  // each word: low byte is the even address byte, high byte the odd one
  assign lo_word   = {word_q[1], word_q[0]};
  assign hi_half   = word_q[2];
  assign group_bit = word_q[0][0];
  assign nonzero   = |{word_q[2], word_q[1], word_q[0]};
endmodule

// File: rtl/alt_addr_seq.sv
module alt_addr_seq
  import alt_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             port_func,
  input  logic             rd_ack,
  input  logic             rd_err,
  input  logic             ptr_absent,
  input  logic             group_bit,
  output logic             rd_req,
  output rd_sel_e          rd_sel,
  output logic             ptr_load,
  output logic             word_en,
  output logic [IDX_W-1:0] idx,
  output logic             port1,
  output logic             wr_en,
  output logic             wr_high,
  output logic             busy,
  output logic             done,
  output ld_status_e       status
);
  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  ld_status_e       status_q, status_d;
  logic             port1_q, port1_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    status_d = status_q;
    port1_d  = port1_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d = S_RD_COMPAT;
        idx_d   = '0;
        port1_d = port_func;
      end
      S_RD_COMPAT: if (rd_ack) begin
        if (rd_err) begin state_d = S_FINISH; status_d = ST_ERROR; end
        else state_d = S_RD_PTR;
      end
      S_RD_PTR: if (rd_ack) begin
        if (rd_err)          begin state_d = S_FINISH; status_d = ST_ERROR; end
        else if (ptr_absent) begin state_d = S_FINISH; status_d = ST_NONE; end
        else                 begin state_d = S_RD_WORD; idx_d = '0; end
      end
      S_RD_WORD: if (rd_ack) begin
        if (rd_err) begin state_d = S_FINISH; status_d = ST_ERROR; end
        else if (idx_q == IDX_W'(NUM_WORDS - 1)) state_d = S_CHECK;
        else idx_d = idx_q + 1'b1;
      end
      S_CHECK: begin
        if (group_bit) begin state_d = S_FINISH; status_d = ST_IGNORED; end
        else state_d = S_WR_LO;
      end
      S_WR_LO:  state_d = S_GAP;
      S_GAP:    state_d = S_WR_HI;
      S_WR_HI:  begin state_d = S_FINISH; status_d = ST_WRITTEN; end
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      status_q <= ST_WRITTEN;
      port1_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      status_q <= status_d;
      port1_q  <= port1_d;
    end
  end

  assign rd_req   = (state_q == S_RD_COMPAT) || (state_q == S_RD_PTR) ||
                    (state_q == S_RD_WORD);
  assign rd_sel   = (state_q == S_RD_COMPAT) ? SEL_COMPAT :
                    (state_q == S_RD_PTR)    ? SEL_PTR : SEL_WORD;
  assign ptr_load = (state_q == S_RD_PTR) && rd_ack && !rd_err;
  assign word_en  = (state_q == S_RD_WORD) && rd_ack && !rd_err;
  assign idx      = idx_q;
  assign port1    = port1_q;
  assign wr_en    = (state_q == S_WR_LO) || (state_q == S_WR_HI);
  assign wr_high  = (state_q == S_WR_HI);
  assign busy     = (state_q != S_IDLE);
  assign done     = (state_q == S_FINISH);
  assign status   = status_q;
endmodule

// File: rtl/alt_addr_loader.sv
module alt_addr_loader
  import alt_addr_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter logic [15:0] COMPAT_ADDR = 16'h0003,
  parameter logic [15:0] PTR_ADDR    = 16'h0037,
  parameter logic [15:0] PORT1_OFS   = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          port_func,
  output logic          nvm_rd_req,
  output logic [AW-1:0] nvm_rd_addr,
  input  logic          nvm_rd_ack,
  input  logic [15:0]   nvm_rd_data,
  input  logic          nvm_rd_err,
  output logic          rar_wr_en,
  output logic          rar_wr_high,
  output logic [31:0]   rar_wr_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status
);
  localparam int unsigned HI_PAD = 32 - 16 - 1;

  rd_sel_e          rd_sel;
  logic             ptr_load, word_en, port1, ptr_absent;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    word_addr;
  logic [31:0]      lo_word;
  logic [15:0]      hi_half;
  logic             group_bit, nonzero;
  ld_status_e       status_e;

  alt_addr_seq u_seq (
    .clk, .rst_n, .start, .port_func,
    .rd_ack(nvm_rd_ack), .rd_err(nvm_rd_err),
    .ptr_absent, .group_bit,
    .rd_req(nvm_rd_req), .rd_sel, .ptr_load, .word_en, .idx, .port1,
    .wr_en(rar_wr_en), .wr_high(rar_wr_high),
    .busy, .done, .status(status_e)
  );

  alt_addr_ptr_calc #(.AW(AW), .PORT1_OFS(PORT1_OFS)) u_ptr (
    .clk, .rst_n, .load(ptr_load), .port1, .ptr_in(nvm_rd_data),
    .idx, .ptr_absent, .word_addr
  );

  alt_addr_word_store u_words (
    .clk, .rst_n, .wr_en(word_en), .idx, .data(nvm_rd_data),
    .lo_word, .hi_half, .group_bit, .nonzero
  );

  always_comb begin
    unique case (rd_sel)
      SEL_COMPAT: nvm_rd_addr = AW'(COMPAT_ADDR);
      SEL_PTR:    nvm_rd_addr = AW'(PTR_ADDR);
      default:    nvm_rd_addr = word_addr;
    endcase
  end

  assign rar_wr_data = rar_wr_high ? {nonzero, {HI_PAD{1'b0}}, hi_half} : lo_word;
  assign status      = status_e;
endmodule

// File: rtl/alt_addr_loader_chk.sv
module alt_addr_loader_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nvm_rd_req,
  input logic [AW-1:0] nvm_rd_addr,
  input logic          nvm_rd_ack,
  input logic          rar_wr_en,
  input logic          rar_wr_high,
  input logic [31:0]   rar_wr_data,
  input logic          busy,
  input logic          done,
  input logic [1:0]    status
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_rd_req && !nvm_rd_ack) |=> (nvm_rd_req && $stable(nvm_rd_addr)));
  // R12
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nvm_rd_req && rar_wr_en));
  // R10
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rar_wr_en && rar_wr_high) |-> $past(rar_wr_en && !rar_wr_high, 2));
  // R9
  hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rar_wr_en && rar_wr_high) |-> (rar_wr_data[30:16] == 15'd0));
  // R10
  written_has_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> $past(rar_wr_en && rar_wr_high, 1));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind alt_addr_loader alt_addr_loader_chk #(.AW(AW)) u_chk (
  .clk, .rst_n, .nvm_rd_req, .nvm_rd_addr, .nvm_rd_ack,
  .rar_wr_en, .rar_wr_high, .rar_wr_data, .busy, .done, .status
);

// File: tb/alt_addr_loader_bench.sv
`timescale 1ns/1ps
module alt_addr_loader_bench;
  localparam logic [15:0] COMPAT_A = 16'h0003;
  localparam logic [15:0] PTR_A    = 16'h0037;
  localparam logic [15:0] OFS      = 16'h0003;
  localparam int          LAT      = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        port_func = 1'b0;
  logic        nvm_rd_req;
  logic [15:0] nvm_rd_addr;
  logic        nvm_rd_ack = 1'b0;
  logic [15:0] nvm_rd_data = '0;
  logic        nvm_rd_err = 1'b0;
  logic        rar_wr_en, rar_wr_high, busy, done;
  logic [31:0] rar_wr_data;
  logic [1:0]  status;

  always #2 clk = ~clk;

  alt_addr_loader u_alt_addr_loader (
    .clk, .rst_n, .start, .port_func,
    .nvm_rd_req, .nvm_rd_addr, .nvm_rd_ack, .nvm_rd_data, .nvm_rd_err,
    .rar_wr_en, .rar_wr_high, .rar_wr_data, .busy, .done, .status
  );

  int checks = 0, failures = 0, cyc = 0;
  int cnt = 0, rd_n = 0, err_idx = -1, wr_n = 0, done_n = 0;
  logic [15:0] ptr_val, base, w [3];
  logic [15:0] rd_log [8];
  logic [31:0] wr_data [4];
  logic        wr_hi [4];
  int          wr_cyc [4];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lookup(input logic [15:0] a);
    if (a == COMPAT_A) return 16'hC0DE;
    if (a == PTR_A)    return ptr_val;
    for (int k = 0; k < 3; k++) if (a == base + 16'(k)) return w[k];
    return 16'hDEAD;
  endfunction

  // memory model and output monitor, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (nvm_rd_ack) begin
      nvm_rd_ack = 1'b0; nvm_rd_err = 1'b0; cnt = 0;
    end else if (nvm_rd_req) begin
      cnt++;
      if (cnt == LAT) begin
        nvm_rd_ack  = 1'b1;
        nvm_rd_data = lookup(nvm_rd_addr);
        nvm_rd_err  = (rd_n == err_idx);
        if (rd_n < 8) rd_log[rd_n] = nvm_rd_addr;
        rd_n++;
      end
    end
    if (rar_wr_en) begin
      if (wr_n < 4) begin
        wr_data[wr_n] = rar_wr_data; wr_hi[wr_n] = rar_wr_high; wr_cyc[wr_n] = cyc;
      end
      wr_n++;
    end
    if (done) done_n++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_case(input bit port, input logic [15:0] ptr,
                          input logic [15:0] a0, input logic [15:0] a1,
                          input logic [15:0] a2, input int err);
    bit absent;
    int exp_rd, exp_st, wait_n;
    logic [47:0] mac;
    ptr_val = ptr; w[0] = a0; w[1] = a1; w[2] = a2; err_idx = err;
    base = ptr + (port ? OFS : 16'h0000);
    @(negedge clk);
    rd_n = 0; wr_n = 0; done_n = 0;
    port_func = port; start = 1'b1;
    @(negedge clk);
    start = 1'b0; port_func = ~port;
    @(negedge clk);
    start = 1'b1;                       // ignored: run is busy
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 200) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    @(negedge clk);
    absent = (ptr == 16'h0000) || (ptr == 16'hFFFF);
    mac = {a2, a1, a0};
    if (err == 0 || err == 1)        begin exp_rd = err + 1; exp_st = 3; end
    else if (absent)                 begin exp_rd = 2;       exp_st = 1; end
    else if (err >= 2 && err <= 4)   begin exp_rd = err + 1; exp_st = 3; end
    else if (a0[0])                  begin exp_rd = 5;       exp_st = 2; end
    else                             begin exp_rd = 5;       exp_st = 0; end
    // R11: one done pulse, extra start caused no second run, status held
    chk(done_n == 1, "R11 done count", done_n, 1);
    chk(status == 2'(exp_st), "R3/R4/R7/R10 status", status, exp_st);
    chk(rd_n == exp_rd, "R3/R4 read count", rd_n, exp_rd);
    // R2: fixed first two addresses
    if (rd_n >= 1) chk(rd_log[0] == COMPAT_A, "R2 first read", rd_log[0], COMPAT_A);
    if (rd_n >= 2) chk(rd_log[1] == PTR_A, "R2 second read", rd_log[1], PTR_A);
    // R5: word addresses from base with offset and wrap
    for (int k = 2; k < rd_n && k < 5; k++)
      chk(rd_log[k] == base + 16'(k - 2), "R5 word address", rd_log[k], base + 16'(k - 2));
    if (exp_st == 0) begin
      chk(wr_n == 2, "R10 write count", wr_n, 2);
      chk(!wr_hi[0] && wr_hi[1], "R10 order", {wr_hi[0], wr_hi[1]}, 2'b01);
      chk(wr_cyc[1] - wr_cyc[0] == 2, "R10 spacing", wr_cyc[1] - wr_cyc[0], 2);
      // R6 R8: bytes 0..3, byte0 from a0 low byte
      chk(wr_data[0] == {mac[31:24], mac[23:16], mac[15:8], mac[7:0]},
          "R6 R8 low data", wr_data[0], mac[31:0]);
      chk(wr_data[1] == {(mac != 48'd0), 15'd0, mac[47:32]}, "R9 high data",
          wr_data[1], {(mac != 48'd0), 15'd0, mac[47:32]});
    end else begin
      // R3 R4 R7: no register writes
      chk(wr_n == 0, "R3/R4/R7 no write", wr_n, 0);
    end
  endtask

  initial begin
    logic [15:0] ptrs [4];
    logic [15:0] pw [5][3];
    ptrs[0] = 16'h0000; ptrs[1] = 16'hFFFF; ptrs[2] = 16'h0010; ptrs[3] = 16'hFFFC;
    pw[0][0] = 16'h1A02; pw[0][1] = 16'h3C4B; pw[0][2] = 16'h5E6D;   // unicast
    pw[1][0] = 16'h1A03; pw[1][1] = 16'h3C4B; pw[1][2] = 16'h5E6D;   // group
    pw[2][0] = 16'h0000; pw[2][1] = 16'h0000; pw[2][2] = 16'h0000;   // zero
    pw[3][0] = 16'h0000; pw[3][1] = 16'h0000; pw[3][2] = 16'h8000;   // top byte only
    pw[4][0] = 16'hFE00; pw[4][1] = 16'h0000; pw[4][2] = 16'h0000;   // byte 1 only
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !nvm_rd_req && !rar_wr_en && status == 2'd0, "R1 reset",
        {busy, done, nvm_rd_req, rar_wr_en, status}, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !nvm_rd_req && !rar_wr_en && status == 2'd0, "R1 after reset",
        {busy, done, nvm_rd_req, rar_wr_en, status}, 6'd0);
    for (int p = 0; p < 2; p++)
      for (int q = 0; q < 4; q++)
        for (int s = 0; s < 5; s++)
          for (int e = -1; e < 5; e++)
            run_case(p[0], ptrs[q], pw[s][0], pw[s][1], pw[s][2], e);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule